// File: doc/BRIEF.md
# Synchronizable PWM Switching-Cycle Timebase

This block sets the timebase for a fixed-frequency pulse-width modulator. A counter runs through a programmable number of clocks and starts again. Each time it starts over, the block raises a one-clock start strobe. The counter value is also given out as a ramp that a comparator in the modulator can use. With a 50 MHz clock, the default period of 200 clocks gives a 250 kHz switching rate. The period setting can bring that down to 50 clocks, which is a 1 MHz rate.

The block also drives one end of a shared synchronization line. When it runs on its own, it sends a fixed-width pulse halfway through every cycle. A peer unit on the same line can lock to that pulse. When a rising edge arrives on the line from outside, the block restarts its own cycle at that edge. It then goes quiet as a slave until one of its cycles ends by its own count.

When two units are wired together, the one with the shorter period becomes master. The other unit then switches half a period later than the master. For the slave to lock, its free-running period should be set a little longer than the master's period, because an external restart cuts the ramp short.

Top module: `pwm_sync_clkgen`

## Requirements
- R1: While `rst` is high, `rampVal` is 0, and `cycleStart`, `syncOut` and `syncOe` are all 0.
- R2: `rampVal` goes up by one every clock. It goes back to 0 on a cycle restart. `cycleStart` is high for exactly the one clock in which `rampVal` is 0 after a restart.
- R3: The cycle length in clocks is set by `periodSet`:
  - a value of 0 selects 200 clocks;
  - a value from 50 to 200 gives that many clocks;
  - a value below 50 gives 50 clocks;
  - a value above 200 gives 200 clocks.
- R4: In free-running mode, `syncOut` rises in the clock where `rampVal` equals floor(period/2). It stays high for 6 clocks (120 ns). `syncOe` is high in exactly those clocks.
- R5: A rising edge on `syncIn` that is first sampled at clock edge k restarts the cycle at edge k+2, whatever the ramp value is. In the clock after that edge, `cycleStart` is 1 and `rampVal` is 0.
- R6: After an external restart, `syncOut` and `syncOe` stay 0 until a cycle ends because its own count ran out.
- R7: A rising edge on `syncIn` is ignored if it is detected while the block is driving its own sync pulse, so the block's own pulse echoing back on the line does not restart it.
- R8: If `periodSet` is lowered so that the ramp is already at or past the new last count, the cycle ends at the next clock edge.
- R9: Once external pulses stop, the cycle ends at its own period, and half-period sync pulses start again in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| periodSet | input | 16 | Requested cycle length in clocks; 0 selects the default |
| syncIn | input | 1 | Synchronization line as received; asynchronous |
| cycleStart | output | 1 | One-clock strobe at the start of each cycle |
| rampVal | output | 16 | Position within the current cycle |
| syncOut | output | 1 | Sync pulse to drive onto the line |
| syncOe | output | 1 | Output enable for the sync line driver |

## Verification
The assertions assume the following about the inputs:
- `syncIn` pulses are separated by more clocks than the synchronizer and edge detector need to settle;
- `periodSet` changes only between whole clocks;
- the block's own pulse can only echo back onto `syncIn` while that pulse is still being driven.

The stimulus stays within these limits. External pulses are spaced 150 clocks apart and are 6 clocks wide. The echo test raises `syncIn` only while `syncOut` is high. Every period change is applied on the falling clock edge.

// File: rtl/pwm_clkgen_pkg.sv
package pwm_clkgen_pkg;

  // Strobes from control to datapath, valid for one clock.
  typedef struct packed {
    logic restart;     // zero the ramp at the coming edge
    logic extRestart;  // restart caused by the sync line
    logic launch;      // load the sync pulse counter
  } strobe_t;

endpackage

// File: rtl/pwm_sync_input.sv
module pwm_sync_input #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic syncIn,
  output logic extRise
);
  localparam int TAP_W = SYNC_STAGES + 1;

  logic [TAP_W-1:0] taps;

  always_ff @(posedge clk) begin
    if (rst) taps <= '0;
    else     taps <= {taps[TAP_W-2:0], syncIn};
  end

  // A rise is seen when the last synchronizer stage is 1 and the
  // extra history flop behind it is still 0.
  assign extRise = taps[TAP_W-2] & ~taps[TAP_W-1];
endmodule

// File: rtl/pwm_datapath.sv
module pwm_datapath
  import pwm_clkgen_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int MIN_PERIOD = 50,
  parameter int MAX_PERIOD = 200,
  parameter int PULSE_LEN  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] periodSet,
  input  strobe_t          stb,
  output logic [CNT_W-1:0] rampCnt,
  output logic             expire,
  output logic             halfHit,
  output logic             pulseActive
);
  localparam int              PW_W  = $clog2(PULSE_LEN + 1);
  localparam logic [CNT_W-1:0] MIN_P = CNT_W'(MIN_PERIOD);
  localparam logic [CNT_W-1:0] MAX_P = CNT_W'(MAX_PERIOD);
  localparam logic [PW_W-1:0]  PW_LD = PW_W'(PULSE_LEN);

  logic [CNT_W-1:0] periodEff;
  logic [CNT_W-1:0] halfPoint;
  logic [PW_W-1:0]  pulseCnt;

  // Period clamp: 0 selects the default (longest) period.
  always_comb begin
    if (periodSet == '0 || periodSet > MAX_P) periodEff = MAX_P;
    else if (periodSet < MIN_P)               periodEff = MIN_P;
    else                                      periodEff = periodSet;
  end

  assign halfPoint = periodEff >> 1;
  assign expire    = (rampCnt >= periodEff - 1'b1);
  assign halfHit   = (rampCnt == halfPoint - 1'b1);

  always_ff @(posedge clk) begin
    if (rst)              rampCnt <= '0;
    else if (stb.restart) rampCnt <= '0;
    else                  rampCnt <= rampCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                   pulseCnt <= '0;
    else if (stb.extRestart)   pulseCnt <= '0;
    else if (stb.launch)       pulseCnt <= PW_LD;
    else if (pulseCnt != '0)   pulseCnt <= pulseCnt - 1'b1;
  end

  assign pulseActive = (pulseCnt != '0);
endmodule

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_clkgen_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    expire,
  input  logic    halfHit,
  input  logic    pulseActive,
  input  logic    extRise,
  output strobe_t stb,
  output logic    cycleStart
);
  logic slaveMode;
  logic extTake;

  // Ignore a rise while this unit's own pulse is on the line.
  assign extTake        = extRise & ~pulseActive;
  assign stb.extRestart = extTake;
  assign stb.restart    = expire | extTake;
  assign stb.launch     = halfHit & ~slaveMode & ~stb.restart;

  always_ff @(posedge clk) begin
    if (rst) begin
      cycleStart <= 1'b0;
      slaveMode  <= 1'b0;
    end else begin
      cycleStart <= stb.restart;
      if (extTake)     slaveMode <= 1'b1;
      else if (expire) slaveMode <= 1'b0;
    end
  end
endmodule

// File: rtl/pwm_sync_clkgen.sv
module pwm_sync_clkgen
  import pwm_clkgen_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int MIN_PERIOD  = 50,
  parameter int MAX_PERIOD  = 200,
  parameter int PULSE_LEN   = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] periodSet,
  input  logic             syncIn,
  output logic             cycleStart,
  output logic [CNT_W-1:0] rampVal,
  output logic             syncOut,
  output logic             syncOe
);
  strobe_t stb;
  logic    extRise;
  logic    expire;
  logic    halfHit;
  logic    pulseActive;
  logic    extRestartW;

  pwm_sync_input #(.SYNC_STAGES(SYNC_STAGES)) i_syncIn (
    .clk(clk), .rst(rst), .syncIn(syncIn), .extRise(extRise)
  );

  pwm_ctrl i_ctrl (
    .clk(clk), .rst(rst), .expire(expire), .halfHit(halfHit),
    .pulseActive(pulseActive), .extRise(extRise),
    .stb(stb), .cycleStart(cycleStart)
  );

  pwm_datapath #(
    .CNT_W(CNT_W), .MIN_PERIOD(MIN_PERIOD),
    .MAX_PERIOD(MAX_PERIOD), .PULSE_LEN(PULSE_LEN)
  ) i_dp (
    .clk(clk), .rst(rst), .periodSet(periodSet), .stb(stb),
    .rampCnt(rampVal), .expire(expire), .halfHit(halfHit),
    .pulseActive(pulseActive)
  );

  assign extRestartW = stb.extRestart;
  assign syncOut     = pulseActive;
  assign syncOe      = pulseActive;
endmodule

// File: rtl/pwm_clkgen_checker.sv
module pwm_clkgen_checker #(
  parameter int CNT_W      = 16,
  parameter int MAX_PERIOD = 200,
  parameter int PULSE_LEN  = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             cycleStart,
  input logic [CNT_W-1:0] rampVal,
  input logic             syncOut,
  input logic             syncOe,
  input logic             extRestart
);
  localparam logic [7:0]       PW_EXP = 8'(PULSE_LEN);
  localparam logic [CNT_W-1:0] MAX_P  = CNT_W'(MAX_PERIOD);

  logic [7:0] highRun;

  always_ff @(posedge clk) begin
    if (rst)          highRun <= '0;
    else if (syncOut) highRun <= highRun + 1'b1;
    else              highRun <= '0;
  end

  // R2: a cycle start always shows a zero ramp
  p_start_zero_r2: assert property (@(posedge clk) disable iff (rst)
    cycleStart |-> rampVal == '0);

  // R2: a non-zero ramp is one more than the value before it
  p_ramp_step_r2: assert property (@(posedge clk) disable iff (rst)
    (rampVal != '0) |-> rampVal == $past(rampVal) + 1'b1);

  // R3: the ramp never reaches the longest period
  p_ramp_bound_r3: assert property (@(posedge clk) disable iff (rst)
    rampVal < MAX_P);

  // R4: every sync pulse lasts the fixed width
  p_pulse_width_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(syncOut) |-> highRun == PW_EXP);

  // R5: an accepted external edge restarts the cycle at the next edge
  p_ext_restart_r5: assert property (@(posedge clk) disable iff (rst)
    extRestart |=> (cycleStart && rampVal == '0));

  // R6: no driving just after an external restart
  p_slave_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    extRestart |=> !syncOe);
endmodule

bind pwm_sync_clkgen pwm_clkgen_checker #(
  .CNT_W(CNT_W), .MAX_PERIOD(MAX_PERIOD), .PULSE_LEN(PULSE_LEN)
) i_chk (
  .clk(clk), .rst(rst), .cycleStart(cycleStart), .rampVal(rampVal),
  .syncOut(syncOut), .syncOe(syncOe), .extRestart(extRestartW)
);

// File: tb/test_pwm_sync_clkgen.sv
module test_pwm_sync_clkgen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] periodSet = '0;
  logic        syncIn = 1'b0;
  logic        cycleStart;
  logic [15:0] rampVal;
  logic        syncOut;
  logic        syncOe;

  int nChecks = 0;
  int nFail   = 0;

  localparam int NVEC = 6;
  localparam int VEC_SET [NVEC] = '{0, 50, 10, 120, 300, 199};
  localparam int VEC_EXP [NVEC] = '{200, 50, 50, 120, 200, 199};

  pwm_sync_clkgen i_pwm_sync_clkgen (
    .clk(clk), .rst(rst), .periodSet(periodSet), .syncIn(syncIn),
    .cycleStart(cycleStart), .rampVal(rampVal),
    .syncOut(syncOut), .syncOe(syncOe)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  task automatic waitStart;
    do @(negedge clk); while (!cycleStart);
  endtask

  // Times one full cycle; records pulse offset and width.
  task automatic measure(output int len, output int off, output int wid,
                         output bit rampOk, output bit oeOk);
    bit prev;
    waitStart();
    len = 0; off = -1; wid = 0; rampOk = 1; oeOk = 1; prev = 0;
    do begin
      @(negedge clk);
      len++;
      if (!cycleStart && rampVal != 16'(len)) rampOk = 0;
      if (syncOe !== syncOut) oeOk = 0;
      if (syncOut) begin
        if (!prev) off = len;
        wid++;
      end
      prev = syncOut;
    end while (!cycleStart);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int len, off, wid, cnt, echoT;
    bit rampOk, oeOk, quietOk;

    // R1 reset state
    repeat (3) @(negedge clk);
    check(rampVal == 0,    "R1 ramp",  rampVal, 0);
    check(!cycleStart,     "R1 start", cycleStart, 0);
    check(!syncOut,        "R1 sync",  syncOut, 0);
    check(!syncOe,         "R1 oe",    syncOe, 0);
    rst = 1'b0;

    // R3/R4/R2 table of period settings
    for (int i = 0; i < NVEC; i++) begin
      periodSet = 16'(VEC_SET[i]);
      measure(len, off, wid, rampOk, oeOk);
      check(len == VEC_EXP[i],     "R3 period",       len, VEC_EXP[i]);
      check(off == VEC_EXP[i] / 2, "R4 pulse offset", off, VEC_EXP[i] / 2);
      check(wid == 6,              "R4 pulse width",  wid, 6);
      check(rampOk,                "R2 ramp step",    rampOk, 1);
      check(oeOk,                  "R4 oe tracks",    oeOk, 1);
    end

    // R8 shorten period below current count
    periodSet = 16'd0;
    waitStart();
    repeat (150) @(negedge clk);
    periodSet = 16'd60;
    @(negedge clk);
    check(cycleStart && rampVal == 0, "R8 early end", cycleStart, 1);
    measure(len, off, wid, rampOk, oeOk);
    check(len == 60, "R8 new period", len, 60);

    // R5/R6 lock to external pulses 150 clocks apart
    periodSet = 16'd0;
    waitStart();
    repeat (20) @(negedge clk);
    for (int p = 0; p < 4; p++) begin
      syncIn = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(cycleStart && rampVal == 0, "R5 ext restart", rampVal, 0);
      quietOk = 1;
      for (int j = 1; j < 148; j++) begin
        @(negedge clk);
        if (j == 3) syncIn = 1'b0;
        if (syncOe || syncOut) quietOk = 0;
      end
      check(quietOk, "R6 slave quiet", quietOk, 1);
    end

    // R9 external pulses stop: own expiry then master again
    measure(len, off, wid, rampOk, oeOk);
    check(len == 200, "R9 period", len, 200);
    check(off == 100, "R9 pulse back", off, 100);

    // R7 echo of own pulse is ignored
    waitStart();
    cnt = 0; echoT = -1;
    do begin
      @(negedge clk);
      cnt++;
      if (syncOut && echoT < 0) begin
        syncIn = 1'b1;
        echoT = cnt;
      end
      if (echoT >= 0 && cnt == echoT + 6) syncIn = 1'b0;
    end while (!cycleStart);
    check(cnt == 200, "R7 echo ignored", cnt, 200);

    summary();
    $finish;
  end
endmodule